// File: doc/BRIEF.md
# Sequential Keypad Combination Lock

This block turns ten push-button inputs, one for each decimal digit, into a single unlock signal. The secret code is set by parameters. It holds one to nine digits, and no digit may appear twice. Each raw key line passes through a two-flop synchronizer and a settle filter. The lock then tracks how far into the code the user has progressed.

A digit counts only when the expected key is released, not when it is pressed. Any other key resets progress. So does holding two keys at once, or leaving the keypad idle too long between digits. Holding a key keeps the idle window open, and a fresh window begins at release.

Once the final digit is accepted, the unlock output stays high. It stays high until a synchronous reset or the next key press. Such a press relocks the block and starts a new entry.

Top module: `combo_lock`

## Requirements
- R1: After a synchronous reset (active-high `rst`), the lock is at the first code position and `unlock` is 0.
- R2: A key level shorter than `SETTLE_CYCLES` clock cycles after synchronization is ignored: it neither advances nor resets the entry.
- R3: Progress advances by one position only on the filtered release of the expected key, and only if that key's press was accepted at that position. Holding the last key keeps `unlock` at 0 until it is released.
- R4: Pressing a digit that is not part of the code resets the entry to the first position.
- R5: Pressing a code digit out of its turn resets the entry to the first position.
- R6: After at least one accepted digit, if no key is held for `IDLE_CYCLES` consecutive cycles, the entry resets to the first position.
- R7: While any key is held, the idle timer is reloaded, so a hold longer than `IDLE_CYCLES` does not expire the entry.
- R8: `unlock` is 1 exactly when all `CODE_LEN` digits have been accepted, and it then remains 1 with no key press, however long the keypad stays idle.
- R9: Any key press while unlocked drives `unlock` to 0 and restarts entry. The release of that key does not count as a digit.
- R10: Two or more keys held at once after filtering count as a wrong entry and reset to the first position.
- R11: If the expected key's release and another key's press are filtered in the same cycle, the reset wins and no digit is accepted.
- R12: The code is a packed parameter `CODE` of 4-bit digits, first digit in bits [3:0], with `CODE_LEN` from 1 to 9. A one-digit code unlocks after a single correct press and release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| keys | input | 10 | Raw key levels, bit n is digit n, 1 = pressed |
| unlock | output | 1 | High once the full code has been entered |

## Verification
Two functions can collide in one cycle: the release of the expected key, which would advance progress, and the press of a different key, which demands a reset. The bench provokes this by dropping the expected key and raising another raw key on the same clock edge. Both then travel through identical synchronizer and settle paths and emerge together. The lock passes only if the entry is reset and the lock stays closed; a cycle-accurate model checks this on every clock. The same model also covers the meeting of an expiring idle timer with a newly filtered press, where the press must reload the timer.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int NUM_KEYS   = 10;
  localparam int DIGIT_W    = 4;
  localparam int MAX_DIGITS = 9;
  localparam int CODE_W     = DIGIT_W * MAX_DIGITS;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic advance;    // accept one digit
    logic clear;      // return to first position
    logic holdTimer;  // keep idle timer at zero
  } lock_strobe_t;
endpackage

// File: rtl/key_debounce.sv
module key_debounce #(
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic level
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYCLES - 1);

  logic syncA, syncB;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      level  <= 1'b0;
      runCnt <= '0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (syncB == level) begin
        runCnt <= '0;
      end else if (runCnt == CNT_LAST) begin
        level  <= syncB;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_datapath.sv
module lock_datapath import lock_pkg::*; #(
  parameter int unsigned SETTLE_CYCLES = 4,
  parameter int unsigned IDLE_CYCLES   = 64,
  parameter int          STEP_W        = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keysRaw,
  input  lock_strobe_t        strobe,
  output logic [NUM_KEYS-1:0] keyStable,
  output logic [NUM_KEYS-1:0] keyPress,
  output logic [NUM_KEYS-1:0] keyRelease,
  output logic [STEP_W-1:0]   step,
  output logic                timerDone
);
  localparam int TW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
  localparam logic [TW-1:0] TIMER_LAST = TW'(IDLE_CYCLES - 1);

  logic [NUM_KEYS-1:0] stablePrev;
  logic [TW-1:0]       idleTimer;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    key_debounce #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_deb (
      .clk   (clk),
      .rst   (rst),
      .rawIn (keysRaw[k]),
      .level (keyStable[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) stablePrev <= '0;
    else     stablePrev <= keyStable;
  end

  assign keyPress   = keyStable & ~stablePrev;
  assign keyRelease = ~keyStable & stablePrev;
  assign timerDone  = (idleTimer == TIMER_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idleTimer <= '0;
    end else if (strobe.holdTimer || strobe.clear || strobe.advance) begin
      idleTimer <= '0;
    end else if (!timerDone) begin
      idleTimer <= idleTimer + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) step <= '0;
    else if (strobe.advance) step <= step + 1'b1;
  end
endmodule

// File: rtl/lock_control.sv
module lock_control import lock_pkg::*; #(
  parameter int                CODE_LEN = 4,
  parameter logic [CODE_W-1:0] CODE     = 36'h0_0000_7502,
  parameter int                STEP_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keyStable,
  input  logic [NUM_KEYS-1:0] keyPress,
  input  logic [NUM_KEYS-1:0] keyRelease,
  input  logic [STEP_W-1:0]   step,
  input  logic                timerDone,
  output lock_strobe_t        strobe
);
  logic                armed;
  logic [DIGIT_W-1:0]  expDigit;
  logic [NUM_KEYS-1:0] expMask;
  logic unlocked, multiHeld, wrongPress, timeoutHit;

  always_comb begin
    expDigit = '0;
    for (int k = 0; k < CODE_LEN; k++) begin
      if (step == STEP_W'(k)) expDigit = CODE[DIGIT_W*k +: DIGIT_W];
    end
  end

  assign expMask   = NUM_KEYS'(1) << expDigit;
  assign unlocked  = (step == STEP_W'(CODE_LEN));
  assign multiHeld = |(keyStable & (keyStable - 1'b1));

  always_comb begin
    wrongPress       = unlocked ? (|keyPress) : (|(keyPress & ~expMask));
    strobe.holdTimer = (|keyStable) || (step == '0) || unlocked;
    timeoutHit       = timerDone && !strobe.holdTimer;
    strobe.clear     = wrongPress || multiHeld || timeoutHit;
    strobe.advance   = !strobe.clear && !unlocked && armed &&
                       (|(keyRelease & expMask));
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clear || strobe.advance) armed <= 1'b0;
    else if (!unlocked && (|(keyPress & expMask))) armed <= 1'b1;
  end
endmodule

// File: rtl/combo_lock.sv
module combo_lock import lock_pkg::*; #(
  parameter int unsigned       CLK_HZ        = 50_000_000,
  parameter int unsigned       SETTLE_CYCLES = CLK_HZ / 1000 * 33,
  parameter int unsigned       IDLE_CYCLES   = CLK_HZ / 1000 * 3000,
  parameter int                CODE_LEN      = 4,
  parameter logic [CODE_W-1:0] CODE          = 36'h0_0000_7502
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keys,
  output logic                unlock
);
  localparam int STEP_W = $clog2(CODE_LEN + 1);

  lock_strobe_t        strobe;
  logic [NUM_KEYS-1:0] keyStable, keyPress, keyRelease;
  logic [STEP_W-1:0]   step;
  logic                timerDone;

  lock_datapath #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .IDLE_CYCLES   (IDLE_CYCLES),
    .STEP_W        (STEP_W)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .keysRaw    (keys),
    .strobe     (strobe),
    .keyStable  (keyStable),
    .keyPress   (keyPress),
    .keyRelease (keyRelease),
    .step       (step),
    .timerDone  (timerDone)
  );

  lock_control #(
    .CODE_LEN (CODE_LEN),
    .CODE     (CODE),
    .STEP_W   (STEP_W)
  ) u_control (
    .clk        (clk),
    .rst        (rst),
    .keyStable  (keyStable),
    .keyPress   (keyPress),
    .keyRelease (keyRelease),
    .step       (step),
    .timerDone  (timerDone),
    .strobe     (strobe)
  );

  assign unlock = (step == STEP_W'(CODE_LEN));
endmodule

// File: rtl/lock_checker.sv
module lock_checker import lock_pkg::*; #(
  parameter int CODE_LEN = 4,
  parameter int STEP_W   = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                unlock,
  input logic [STEP_W-1:0]   step,
  input logic [NUM_KEYS-1:0] keyStable,
  input logic [NUM_KEYS-1:0] keyPress,
  input logic [NUM_KEYS-1:0] keyRelease,
  input logic                timerDone
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (step == '0 && !unlock));

  assert_no_step_without_release_R3: assert property (@(posedge clk) disable iff (rst)
    !(|keyRelease) |=> (step == '0 || $stable(step)));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (step == '0 || $stable(step) || step == $past(step) + 1'b1));

  assert_idle_expiry_R6: assert property (@(posedge clk) disable iff (rst)
    (timerDone && !(|keyStable) && step != '0 && !unlock) |=> step == '0);

  assert_unlock_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (unlock && !(|keyPress)) |=> unlock);

  assert_press_relocks_R9: assert property (@(posedge clk) disable iff (rst)
    (unlock && (|keyPress)) |=> !unlock);

  assert_multi_key_clears_R10: assert property (@(posedge clk) disable iff (rst)
    ($countones(keyStable) > 1) |=> step == '0);
endmodule

bind combo_lock lock_checker #(
  .CODE_LEN (CODE_LEN),
  .STEP_W   (STEP_W)
) u_lockChecker (
  .clk        (clk),
  .rst        (rst),
  .unlock     (unlock),
  .step       (step),
  .keyStable  (keyStable),
  .keyPress   (keyPress),
  .keyRelease (keyRelease),
  .timerDone  (timerDone)
);

// File: tb/tb_combo_lock.sv
module tb_combo_lock;
  localparam int SETTLE = 4;
  localparam int IDLE   = 60;
  localparam int LEN    = 4;
  localparam int HOLD   = 12;
  localparam int GAP    = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] keys = '0;
  logic       unlock, unlockShort;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  combo_lock #(.SETTLE_CYCLES(SETTLE), .IDLE_CYCLES(IDLE), .CODE_LEN(LEN),
               .CODE(36'h0_0000_7502)) dut (
    .clk(clk), .rst(rst), .keys(keys), .unlock(unlock));

  combo_lock #(.SETTLE_CYCLES(SETTLE), .IDLE_CYCLES(IDLE), .CODE_LEN(1),
               .CODE(36'h0_0000_0009)) dutShort (
    .clk(clk), .rst(rst), .keys(keys), .unlock(unlockShort));

  // ---------------- behavioural reference model ----------------
  int codeDigits[LEN] = '{2, 0, 5, 7};
  int mA[10], mB[10], mLvl[10], mOld[10], mRun[10];
  int mPos, mArm, mIdle;
  bit mValid = 1'b0;

  always @(posedge clk) begin
    int nPress, nHeld, expd;
    bit anyWrong, expPress, expRel, unl, hold, bad, adv;
    if (rst) begin
      for (int i = 0; i < 10; i++) begin
        mA[i] = 0; mB[i] = 0; mLvl[i] = 0; mOld[i] = 0; mRun[i] = 0;
      end
      mPos = 0; mArm = 0; mIdle = 0;
    end else begin
      unl = (mPos == LEN);
      expd = unl ? -1 : codeDigits[mPos];
      nPress = 0; nHeld = 0; anyWrong = 0; expPress = 0; expRel = 0;
      for (int i = 0; i < 10; i++) begin
        if (mLvl[i] == 1) nHeld++;
        if (mLvl[i] == 1 && mOld[i] == 0) begin
          nPress++;
          if (i == expd) expPress = 1; else anyWrong = 1;
        end
        if (mLvl[i] == 0 && mOld[i] == 1 && i == expd) expRel = 1;
      end
      hold = (nHeld > 0) || (mPos == 0) || unl;
      bad  = anyWrong || (nHeld > 1) || (mIdle == IDLE - 1 && !hold);
      adv  = !bad && !unl && (mArm == 1) && expRel;
      if (bad || adv) mArm = 0;
      else if (!unl && expPress) mArm = 1;
      if (hold || bad || adv) mIdle = 0;
      else if (mIdle != IDLE - 1) mIdle++;
      if (bad) mPos = 0;
      else if (adv) mPos++;
      for (int i = 0; i < 10; i++) begin
        mOld[i] = mLvl[i];
        if (mB[i] == mLvl[i]) mRun[i] = 0;
        else if (mRun[i] == SETTLE - 1) begin mLvl[i] = mB[i]; mRun[i] = 0; end
        else mRun[i]++;
        mB[i] = mA[i];
        mA[i] = int'(keys[i]);
      end
    end
    mValid = 1'b1;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R8 output rule)
  always @(negedge clk) begin
    if (mValid && !done)
      check("R8 per-cycle unlock vs model", int'(unlock), int'(mPos == LEN));
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; keys = '0;
    waitCycles(3);
    rst = 1'b0;
    waitCycles(2);
  endtask

  task automatic tap(input int d, input int holdLen);
    @(negedge clk); keys[d] = 1'b1;
    waitCycles(holdLen);
    keys[d] = 1'b0;
    waitCycles(GAP);
  endtask

  task automatic enterCode();
    for (int i = 0; i < LEN; i++) tap(codeDigits[i], HOLD);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    waitCycles(4);
    rst = 1'b0;
    waitCycles(2);
    check("R1 unlock after reset", int'(unlock), 0);
    check("R1 short code unlock after reset", int'(unlockShort), 0);

    // R8: full code unlocks and stays open while idle
    enterCode();
    check("R8 unlock after full code", int'(unlock), 1);
    waitCycles(5 * IDLE);
    check("R8 unlock held while idle", int'(unlock), 1);

    // R9: a press while unlocked relocks; its release is not a digit
    @(negedge clk); keys[2] = 1'b1;
    waitCycles(HOLD);
    check("R9 unlock cleared by press", int'(unlock), 0);
    keys[2] = 1'b0;
    waitCycles(GAP);
    tap(0, HOLD); tap(5, HOLD); tap(7, HOLD);
    check("R9 relock press not counted as first digit", int'(unlock), 0);

    // R1 (again, mid-run reset) and R3: hold last key, unlock only on release
    doReset();
    check("R1 unlock after mid-run reset", int'(unlock), 0);
    tap(2, HOLD); tap(0, HOLD); tap(5, HOLD);
    @(negedge clk); keys[7] = 1'b1;
    waitCycles(40);
    check("R3 no unlock while last key held", int'(unlock), 0);
    keys[7] = 1'b0;
    waitCycles(GAP);
    check("R3 unlock after last key release", int'(unlock), 1);

    // R4: digit outside the code resets the entry
    doReset();
    tap(2, HOLD); tap(0, HOLD); tap(8, HOLD); tap(5, HOLD); tap(7, HOLD);
    check("R4 foreign digit blocks unlock", int'(unlock), 0);
    enterCode();
    check("R4 fresh entry after foreign digit", int'(unlock), 1);

    // R5: code digit out of turn resets
    doReset();
    tap(2, HOLD); tap(5, HOLD); tap(0, HOLD); tap(7, HOLD);
    check("R5 out-of-order digit blocks unlock", int'(unlock), 0);
    enterCode();
    check("R5 fresh entry after out-of-order digit", int'(unlock), 1);

    // R6: idle too long between digits
    doReset();
    tap(2, HOLD); tap(0, HOLD);
    waitCycles(IDLE + 40);
    tap(5, HOLD); tap(7, HOLD);
    check("R6 idle expiry blocks unlock", int'(unlock), 0);
    enterCode();
    check("R6 fresh entry after idle expiry", int'(unlock), 1);

    // R7: long hold keeps the window open
    doReset();
    tap(2, HOLD);
    tap(0, 3 * IDLE);
    tap(5, HOLD); tap(7, HOLD);
    check("R7 long hold does not expire entry", int'(unlock), 1);

    // R2: short glitch on a wrong key is ignored
    doReset();
    tap(2, HOLD); tap(0, HOLD);
    @(negedge clk); keys[9] = 1'b1;
    waitCycles(2);
    keys[9] = 1'b0;
    waitCycles(GAP);
    tap(5, HOLD); tap(7, HOLD);
    check("R2 glitch ignored", int'(unlock), 1);

    // R10: expected key pressed while a wrong key is still held
    doReset();
    @(negedge clk); keys[9] = 1'b1;
    waitCycles(HOLD);
    keys[2] = 1'b1;
    waitCycles(HOLD);
    keys[2] = 1'b0;
    waitCycles(HOLD);
    keys[9] = 1'b0;
    waitCycles(GAP);
    tap(0, HOLD); tap(5, HOLD); tap(7, HOLD);
    check("R10 two held keys void the entry", int'(unlock), 0);

    // R11: expected release and foreign press in the same cycle
    doReset();
    tap(2, HOLD); tap(0, HOLD); tap(5, HOLD);
    @(negedge clk); keys[7] = 1'b1;
    waitCycles(HOLD);
    keys[7] = 1'b0; keys[3] = 1'b1;
    waitCycles(HOLD);
    check("R11 reset wins over advance (held)", int'(unlock), 0);
    keys[3] = 1'b0;
    waitCycles(GAP);
    check("R11 reset wins over advance (released)", int'(unlock), 0);

    // R12: one-digit code
    doReset();
    check("R12 short code locked before entry", int'(unlockShort), 0);
    tap(9, HOLD);
    check("R12 short code unlocks on one digit", int'(unlockShort), 1);
    check("R12 long code unaffected", int'(unlock), 0);

    finishRun();
  end
endmodule